// File: doc/BRIEF.md
# Low-Frequency Oscillator Enable Controller

This block supervises an external 32.768 kHz clock source. The source is either a crystal across two pads or a clock driven straight into the input pad. Software programs one control word. The word holds an enable bit, a crystal-mode select, a gain code for the analog amplifier, a 4-bit startup code and an on-demand bit. The block then drives the pad overrides and asks the analog oscillator to run. It counts a startup delay on the raw oscillator clock and holds the output clock low until that delay has passed.

When the delay ends, a ready flag crosses into the register clock domain. Its rising edge can raise a sticky interrupt. In sleep, the on-demand bit decides whether the oscillator keeps running or runs only while a peripheral asks for it. After each stop the startup delay counts again. Oscillator state and configuration sit on the power-on reset alone, so a system reset does not disturb a running crystal.

Top module: `losc_ctrl`

## Requirements
- R1: After power-on reset the control word reads 0, and ready, interrupt, run request, both pad overrides and the output clock are all 0. The control word layout is: bit 0 enable, bit 1 crystal mode, bit 2 on-demand, bits 4:3 gain, bits 8:5 startup code. While enable is 0, a write loads every field and reads back unchanged.
- R2: While the stored enable is 1, a write changes only the enable bit, and a 1 in that bit leaves it set. The crystal, on-demand, gain and startup fields keep their values.
- R3: The input-pad override equals the stored enable. The output-pad override is 1 only when enable and crystal mode are both 1.
- R4: The run request is 1 when enable is 1 and any of these holds: on-demand is 0, sleep is 0, or a peripheral request is 1. Otherwise it is 0.
- R5: After the run request rises, the output clock stays low for 2^(N+3) raw-clock cycles, where N is the startup code clamped to at most 12. After that it follows the raw clock.
- R6: Ready rises only after the startup delay ends. It falls within a few raw-clock cycles once the run request drops.
- R7: A write that sets enable while enable is 0 and ready still reads 1 leaves enable at 0. Such a write still loads the other fields.
- R8: A rising edge of ready while the interrupt enable is 1 sets the interrupt flag. The flag holds until a clear strobe. If a set and a clear arrive in the same cycle, the set wins.
- R9: The system reset clears only the interrupt enable and the interrupt flag. The control word, ready and the oscillator keep running. Power-on reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| osc_clk_i | input | 1 | Raw oscillator clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 9 | Control word write data |
| ctrl_o | output | 9 | Stored control word |
| ie_we_i | input | 1 | Interrupt enable write strobe |
| ie_wdata_i | input | 1 | Interrupt enable write data |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| sleep_i | input | 1 | System is in a sleep state |
| periph_req_i | input | 1 | A peripheral requests the clock |
| osc_run_o | output | 1 | Run request to the analog oscillator |
| clk_o | output | 1 | Gated oscillator clock |
| ready_o | output | 1 | Oscillator stable, register clock domain |
| irq_o | output | 1 | Sticky ready interrupt flag |
| pin_in_ovr_o | output | 1 | Input pad taken from GPIO |
| pin_out_ovr_o | output | 1 | Output pad taken from GPIO |

## Verification
The hardest case to reach is the brief window after a disable. In that window the run request has already fallen, but ready still reads 1 because of the two synchronisers. The stimulus writes disable and then, on the very next write slot, writes enable again. This lands inside the window and shows that the enable is refused while the other fields still load. The on-demand wake path is reached by holding sleep with no peripheral request until ready drops. Raising the request then restarts the full startup count. The clamped startup code is run once at full length to show that the delay stops at 2^15 raw cycles.

// File: rtl/losc_pkg.sv
package losc_pkg;
  localparam int unsigned STARTUP_W  = 4;
  localparam int unsigned GAIN_W     = 2;
  localparam int unsigned MAX_CODE   = 12;
  localparam int unsigned BASE_SHIFT = 3;
  localparam int unsigned CNT_W      = MAX_CODE + BASE_SHIFT + 1;
  localparam int unsigned CTRL_W     = 3 + GAIN_W + STARTUP_W;

  typedef struct packed {
    logic [STARTUP_W-1:0] startup;
    logic [GAIN_W-1:0]    gain;
    logic                 on_demand;
    logic                 xtal;
    logic                 enable;
  } ctrl_t;
endpackage

// File: rtl/losc_sync.sv
module losc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/losc_cfg_regs.sv
module losc_cfg_regs
  import losc_pkg::*;
(
  input  logic  clk_i,
  input  logic  por_ni,
  input  logic  we_i,
  input  ctrl_t wdata_i,
  input  logic  ready_i,
  output ctrl_t ctrl_o
);
  ctrl_t q, d;

  always_comb begin
    d = q;
    if (we_i) begin
      if (q.enable) begin
        d.enable = wdata_i.enable;
      end else begin
        d        = wdata_i;
        // refuse re-enable until the previous run has fully drained
        d.enable = wdata_i.enable & ~ready_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) q <= '0;
    else         q <= d;
  end

  assign ctrl_o = q;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!por_ni)
    (q.enable && we_i) |=> ($stable(q.startup) && $stable(q.gain) &&
                            $stable(q.on_demand) && $stable(q.xtal)));  // R2
  AST_NO_REENABLE: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!q.enable && we_i && ready_i) |=> !q.enable);  // R7
endmodule

// File: rtl/losc_startup.sv
module losc_startup
  import losc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 osc_clk_i,
  input  logic                 por_ni,
  input  logic                 run_i,
  input  logic [STARTUP_W-1:0] code_i,
  output logic                 done_o,
  output logic                 gate_o
);
  logic                 run_s;
  logic [STARTUP_W-1:0] code_c;
  int unsigned          sh;
  logic [CNT_W-1:0]     last;
  logic [CNT_W-1:0]     cnt_q;
  logic                 done_q, gate_q;

  losc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk_i (osc_clk_i),
    .rst_ni(por_ni),
    .d_i   (run_i),
    .q_o   (run_s)
  );

  always_comb begin
    code_c = (code_i > STARTUP_W'(MAX_CODE)) ? STARTUP_W'(MAX_CODE) : code_i;
    sh     = int'(code_c) + BASE_SHIFT;
    last   = (CNT_W'(1) << sh) - CNT_W'(1);
  end

  always_ff @(posedge osc_clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_s) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q >= last) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // enable captured on the low phase so the gated clock never clips a pulse
  always_ff @(negedge osc_clk_i or negedge por_ni) begin
    if (!por_ni) gate_q <= 1'b0;
    else         gate_q <= done_q;
  end

  assign done_o = done_q;
  assign gate_o = gate_q;

  AST_GATE_MASK: assert property (@(posedge osc_clk_i) disable iff (!por_ni)
    !done_q |-> !gate_q);  // R5
  AST_DONE_CLEAR: assert property (@(posedge osc_clk_i) disable iff (!por_ni)
    !run_s |=> !done_q);  // R6
endmodule

// File: rtl/losc_irq.sv
module losc_irq (
  input  logic clk_i,
  input  logic por_ni,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic ie_we_i,
  input  logic ie_wdata_i,
  input  logic clr_i,
  output logic irq_o
);
  logic sys_rst_n;
  logic ready_d, ie_q, irq_q;

  assign sys_rst_n = por_ni & rst_ni;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) ready_d <= 1'b0;
    else         ready_d <= ready_i;
  end

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ie_we_i) ie_q <= ie_wdata_i;
      if (ready_i && !ready_d && ie_q) irq_q <= 1'b1;
      else if (clr_i)                  irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (ready_i && !ready_d && ie_q) |=> irq_q);  // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (irq_q && !clr_i) |=> irq_q);  // R8
endmodule

// File: rtl/losc_ctrl.sv
module losc_ctrl
  import losc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              osc_clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              ie_we_i,
  input  logic              ie_wdata_i,
  input  logic              irq_clr_i,
  input  logic              sleep_i,
  input  logic              periph_req_i,
  output logic              osc_run_o,
  output logic              clk_o,
  output logic              ready_o,
  output logic              irq_o,
  output logic              pin_in_ovr_o,
  output logic              pin_out_ovr_o
);
  ctrl_t wdata, cfg;
  logic  run, done, gate;

  assign wdata = ctrl_t'(ctrl_wdata_i);

  losc_cfg_regs u_cfg (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .we_i   (ctrl_we_i),
    .wdata_i(wdata),
    .ready_i(ready_o),
    .ctrl_o (cfg)
  );

  assign run = cfg.enable & (~cfg.on_demand | ~sleep_i | periph_req_i);

  losc_startup #(.SYNC_STAGES(SYNC_STAGES)) u_startup (
    .osc_clk_i(osc_clk_i),
    .por_ni   (por_ni),
    .run_i    (run),
    .code_i   (cfg.startup),
    .done_o   (done),
    .gate_o   (gate)
  );

  losc_sync #(.STAGES(SYNC_STAGES)) u_ready_sync (
    .clk_i (clk_i),
    .rst_ni(por_ni),
    .d_i   (done),
    .q_o   (ready_o)
  );

  losc_irq u_irq (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .rst_ni    (rst_ni),
    .ready_i   (ready_o),
    .ie_we_i   (ie_we_i),
    .ie_wdata_i(ie_wdata_i),
    .clr_i     (irq_clr_i),
    .irq_o     (irq_o)
  );

  assign ctrl_o        = cfg;
  assign osc_run_o     = run;
  assign clk_o         = osc_clk_i & gate;
  assign pin_in_ovr_o  = cfg.enable;
  assign pin_out_ovr_o = cfg.enable & cfg.xtal;
endmodule

// File: tb/losc_ctrl_bench.sv
module losc_ctrl_bench;
  logic       clk = 1'b0, osc = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [8:0] ctrl_wdata = '0;
  logic [8:0] ctrl_rd;
  logic       ie_we = 1'b0, ie_wdata = 1'b0, irq_clr = 1'b0;
  logic       sleep = 1'b0, preq = 1'b0;
  logic       osc_run, clk_gated, ready, irq, pin_in, pin_out;

  int n_chk = 0, n_fail = 0, cyc = 0, n_clko = 0;

  // reference state
  logic [8:0] m_ctrl = '0;
  logic       m_ie = 1'b0, m_irq = 1'b0, rdy_prev = 1'b0;

  losc_ctrl u_losc_ctrl (
    .clk_i(clk), .osc_clk_i(osc), .por_ni(por_n), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_rd),
    .ie_we_i(ie_we), .ie_wdata_i(ie_wdata), .irq_clr_i(irq_clr),
    .sleep_i(sleep), .periph_req_i(preq), .osc_run_o(osc_run),
    .clk_o(clk_gated), .ready_o(ready), .irq_o(irq),
    .pin_in_ovr_o(pin_in), .pin_out_ovr_o(pin_out)
  );

  always #2.5ns clk = ~clk;
  initial begin
    #3ns;
    forever #5ns osc = ~osc;
  end

  always @(posedge clk_gated) n_clko++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // cycle reference model, compared in the low phase of every clock
  always @(negedge clk) begin
    logic rdy_now;
    logic exp_run;
    rdy_now = ready;
    if (!por_n) begin
      m_ctrl = '0; m_ie = 1'b0; m_irq = 1'b0; rdy_prev = 1'b0;
    end
    if (!rst_n) begin
      m_ie = 1'b0; m_irq = 1'b0;
    end
    exp_run = m_ctrl[0] & (~m_ctrl[2] | ~sleep | preq);
    chk(ctrl_rd == m_ctrl, "R1/R2/R7 model ctrl", ctrl_rd, m_ctrl);
    chk(pin_in == m_ctrl[0] && pin_out == (m_ctrl[0] & m_ctrl[1]), "R3 model pins",
        {pin_in, pin_out}, {m_ctrl[0], m_ctrl[0] & m_ctrl[1]});
    chk(osc_run == exp_run, "R4 model run", osc_run, exp_run);
    chk(irq == m_irq, "R8 model irq", irq, m_irq);
    if (por_n) begin
      if (ctrl_we) begin
        if (m_ctrl[0]) m_ctrl[0] = ctrl_wdata[0];
        else begin
          m_ctrl    = ctrl_wdata;
          m_ctrl[0] = ctrl_wdata[0] & ~rdy_now;
        end
      end
      if (rst_n) begin
        if (rdy_now && !rdy_prev && m_ie) m_irq = 1'b1;
        else if (irq_clr)                 m_irq = 1'b0;
        if (ie_we) m_ie = ie_wdata;
      end
      rdy_prev = rdy_now;
    end
  end

  task automatic step();
    @(posedge clk); #1ns;
  endtask

  function automatic logic [8:0] mk(input logic en, input logic xt, input logic od,
                                    input logic [1:0] g, input logic [3:0] st);
    return {st, g, od, xt, en};
  endfunction

  task automatic wr_ctrl(input logic [8:0] d);
    step(); ctrl_we = 1'b1; ctrl_wdata = d;
    step(); ctrl_we = 1'b0;
  endtask

  task automatic wait_osc(input int n);
    repeat (n) @(posedge osc);
    #1ns;
  endtask

  // run request has just risen: expect the masked startup of len raw cycles
  task automatic startup_chk(input int len, input string tag);
    int c0;
    c0 = n_clko;
    wait_osc(len);
    chk(ready == 1'b0, {tag, " R6 not ready early"}, ready, 0);
    chk(n_clko == c0, {tag, " R5 clock masked"}, n_clko - c0, 0);
    wait_osc(4); #3ns;
    chk(ready == 1'b1, {tag, " R6 ready after delay"}, ready, 1);
    c0 = n_clko;
    wait_osc(4);
    chk(n_clko - c0 == 4, {tag, " R5 clock passes"}, n_clko - c0, 4);
  endtask

  task automatic drain_chk(input string tag);
    wait_osc(6); #3ns;
    chk(ready == 1'b0, {tag, " R6 ready clears"}, ready, 0);
  endtask

  initial begin
    repeat (3) step();
    chk(ctrl_rd == 0 && ready == 0 && irq == 0 && osc_run == 0 && pin_in == 0 && pin_out == 0,
        "R1 reset state", {ctrl_rd, ready, irq}, 0);
    por_n = 1'b1; rst_n = 1'b1;
    wait_osc(3);
    chk(n_clko == 0, "R1 no clock while off", n_clko, 0);

    // R1 configuration loads while disabled
    wr_ctrl(mk(0, 1, 0, 2'd2, 4'd5));
    step();
    chk(ctrl_rd == mk(0, 1, 0, 2'd2, 4'd5), "R1 readback", ctrl_rd, mk(0, 1, 0, 2'd2, 4'd5));

    // crystal mode, code 0, interrupt enabled
    step(); ie_we = 1'b1; ie_wdata = 1'b1; step(); ie_we = 1'b0;
    wr_ctrl(mk(1, 1, 0, 2'd1, 4'd0));
    chk(pin_in == 1 && pin_out == 1, "R3 crystal pins", {pin_in, pin_out}, 3);
    startup_chk(8, "code0");
    step();
    chk(irq == 1'b1, "R8 irq on ready", irq, 1);

    // R2 locked fields
    wr_ctrl(mk(1, 0, 1, 2'd3, 4'd9));
    step();
    chk(ctrl_rd == mk(1, 1, 0, 2'd1, 4'd0), "R2 lock", ctrl_rd, mk(1, 1, 0, 2'd1, 4'd0));

    // R8 clear
    step(); irq_clr = 1'b1; step(); irq_clr = 1'b0; step();
    chk(irq == 1'b0, "R8 clear", irq, 0);

    // R9 system reset keeps the oscillator
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    chk(ready == 1 && ctrl_rd == mk(1, 1, 0, 2'd1, 4'd0), "R9 sysreset keeps state",
        {ready, ctrl_rd}, {1'b1, mk(1, 1, 0, 2'd1, 4'd0)});

    // R7 disable then immediate re-enable attempt
    wr_ctrl(mk(0, 1, 0, 2'd1, 4'd0));
    wr_ctrl(mk(1, 0, 0, 2'd0, 4'd2));
    step();
    chk(ctrl_rd == mk(0, 0, 0, 2'd0, 4'd2), "R7 re-enable refused", ctrl_rd, mk(0, 0, 0, 2'd0, 4'd2));
    drain_chk("disable");

    // external clock mode, code 2
    wr_ctrl(mk(1, 0, 0, 2'd0, 4'd2));
    chk(pin_in == 1 && pin_out == 0, "R3 external pins", {pin_in, pin_out}, 2);
    startup_chk(32, "code2");
    step();
    chk(irq == 1'b0, "R9 ie cleared by sysreset", irq, 0);

    // on-demand, code 1
    wr_ctrl(mk(0, 0, 0, 2'd0, 4'd2));
    drain_chk("off2");
    wr_ctrl(mk(1, 1, 1, 2'd0, 4'd1));
    startup_chk(16, "ondemand");
    step(); sleep = 1'b1; preq = 1'b0; step();
    chk(osc_run == 1'b0, "R4 stop in sleep", osc_run, 0);
    drain_chk("sleep");
    preq = 1'b1; step();
    chk(osc_run == 1'b1, "R4 wake on request", osc_run, 1);
    startup_chk(16, "wake");
    sleep = 1'b0; preq = 1'b0; step();
    chk(osc_run == 1'b1, "R4 awake runs", osc_run, 1);

    // R5 clamp: code 15 behaves as 12
    wr_ctrl(mk(0, 1, 0, 2'd0, 4'd1));
    drain_chk("off3");
    wr_ctrl(mk(1, 1, 0, 2'd0, 4'd15));
    startup_chk(32768, "clamp");

    // R9 power-on reset clears everything
    step(); por_n = 1'b0; step(); step();
    chk(ctrl_rd == 0 && ready == 0 && pin_in == 0 && irq == 0, "R9 por clears",
        {ctrl_rd, ready}, 0);
    por_n = 1'b1; step();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule